// File: doc/BRIEF.md
# Search Request Command Decoder

This block is the front end of a ternary search coprocessor. It watches a request strobe and a command bus that carries a three-bit instruction, a lookup-type tag, a global-mask-group select and a register-select field that is time-multiplexed over two clocks. It turns each accepted request into one decoded operation record for the core. The record holds the operation class, the comparand register, the result register, the lookup type, the mask group, a write address and a data word.

Every request takes two cycles. In the first cycle the register-select field names the comparand register, and the request data bus may carry an address. In the second cycle the same field names the result register, and the data bus carries the data word. Fields that have no meaning for a command class are forced to zero in the record. An internal address counter can be loaded from a read or write request and stepped by a burst-advance input, so that data/mask memory can be filled with back-to-back writes and no new address each time.

After reset the block issues nothing until a write to the control address sets its enable bit. Illegal instruction codes, and strobes that land on the second cycle of a pending request, are dropped and reported with one-cycle pulses.

Top module: `srch_cmd_decoder`

## Requirements
- R1: A strobe in an idle cycle starts a two-cycle request. When the request is issued, `op_valid` is high for exactly one cycle, in the cycle after the request's second cycle.
- R2: `op_cmp_sel` equals `cmd_regsel` as sampled in the request's first cycle. `op_res_sel` equals `cmd_regsel` as sampled in its second cycle.
- R3: `op_lktype` carries the first-cycle lookup type only for lookup (code 000) and learn (code 001). For codes 010, 011, 100 and 101 it is zero.
- R4: `op_gmsel` carries the first-cycle mask group only for lookup (000) and write (011). For every other class it is zero.
- R5: Instruction codes are 000 lookup, 001 learn, 010 read, 011 write, 100 SRAM read and 101 SRAM no-wait read. `op_class` reports the code. A strobe with code 110 or 111 in an idle cycle is not issued and does not start a request, and `illegal_cmd` pulses high in the next cycle.
- R6: A strobe during the second cycle of a pending request is rejected, and `proto_err` pulses high in the next cycle. The pending request completes unchanged.
- R7: A read (010) or write (011) strobe with `req_addr_vld` high loads the address counter from `req_data[ADDR_W-1:0]`. An issued record takes `op_addr` from the counter value during the second cycle and `op_data` from `req_data` in the second cycle.
- R8: In a cycle with no load, a high `burst_adv` increments the address counter by one, wrapping at 2^ADDR_W. A load takes priority over an advance.
- R9: Reset clears the counter and the enable bit, and no record is issued while the enable bit is clear. A write (011) with `req_addr_vld` high and address CTRL_ADDR (default 8'hFF) sets the enable bit to bit 0 of the second-cycle data. That control write is itself never issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| req_strobe | input | 1 | Request strobe |
| cmd_instr | input | 3 | Instruction code |
| cmd_lktype | input | LKT_W | Lookup type tag |
| cmd_gmsel | input | GM_W | Global mask group select |
| cmd_regsel | input | RS_W | Register select: comparand in the first cycle, result in the second |
| req_data | input | DATA_W | Address/data word |
| req_addr_vld | input | 1 | First-cycle `req_data` holds an address |
| burst_adv | input | 1 | Step the internal address counter |
| op_valid | output | 1 | Decoded record issued this cycle |
| op_class | output | 3 | Issued instruction code |
| op_cmp_sel | output | RS_W | Comparand register |
| op_res_sel | output | RS_W | Result register |
| op_lktype | output | LKT_W | Lookup type, masked by class |
| op_gmsel | output | GM_W | Mask group, masked by class |
| op_addr | output | ADDR_W | Write/read address from the counter |
| op_data | output | DATA_W | Second-cycle data word |
| illegal_cmd | output | 1 | Illegal-code pulse |
| proto_err | output | 1 | Rejected-strobe pulse |

## Verification
Every instruction code is driven with lookup-type, mask-group and register-select values that are not zero. This shows whether each field reaches the record or is masked for each class, and whether the two select phases are swapped. Address-carrying writes followed by burst-advance pulses, some in the idle gap and some inside a request, and a load near the top of the range, separate load priority, stepping and wrap-around. Strobes in the second cycle, illegal codes, back-to-back requests and toggling the enable bit by control writes show whether stray strobes disturb the sequencer and whether issue is properly gated.

// File: rtl/srch_cmd_pkg.sv
// Shared instruction codes and class predicates for the search request
// decoder. Assumes a three-bit instruction field.
package srch_cmd_pkg;

    typedef enum logic [2:0] {
        OP_LOOKUP  = 3'b000,
        OP_LEARN   = 3'b001,
        OP_READ    = 3'b010,
        OP_WRITE   = 3'b011,
        OP_SRAM_RD = 3'b100,
        OP_SRAM_NW = 3'b101,
        OP_RSVD6   = 3'b110,
        OP_RSVD7   = 3'b111
    } op_code_e;

    function automatic logic code_legal(input logic [2:0] c);
        return (c <= 3'd5);
    endfunction

    function automatic logic code_uses_lktype(input logic [2:0] c);
        return (c == OP_LOOKUP) || (c == OP_LEARN);
    endfunction

    function automatic logic code_uses_gmask(input logic [2:0] c);
        return (c == OP_LOOKUP) || (c == OP_WRITE);
    endfunction

    function automatic logic code_is_rw(input logic [2:0] c);
        return (c == OP_READ) || (c == OP_WRITE);
    endfunction

endpackage

// File: rtl/srch_field_mask.sv
// Combinational field qualifier: zeroes the lookup-type and mask-group
// fields for classes that ignore them and flags illegal codes.
// Assumes the code is the raw first-cycle instruction.
module srch_field_mask
    import srch_cmd_pkg::*;
#(
    parameter int LKT_W = 2,
    parameter int GM_W  = 3
) (
    input  logic [2:0]       code,
    input  logic [LKT_W-1:0] lkt_in,
    input  logic [GM_W-1:0]  gm_in,
    output logic [LKT_W-1:0] lkt_out,
    output logic [GM_W-1:0]  gm_out,
    output logic             legal
);

    // Apply per-class masking of the optional fields.
    always_comb begin
        legal   = code_legal(code);
        lkt_out = code_uses_lktype(code) ? lkt_in : '0;
        gm_out  = code_uses_gmask(code)  ? gm_in  : '0;
    end

endmodule

// File: rtl/srch_burst_ctr.sv
// Internal write-address counter. A load has priority over an advance, and
// the count wraps at 2^ADDR_W. Assumes a synchronous active-low reset.
module srch_burst_ctr #(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] load_val,
    input  logic              adv,
    output logic [ADDR_W-1:0] cnt
);

    // Load, step or hold the address counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (adv) begin
            cnt <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/srch_req_seq.sv
// Two-cycle request sequencer. It captures first-cycle fields, takes the
// result select and data in the second cycle, holds the enable bit and
// issues the decoded record. Assumes the fields are already class-masked.
module srch_req_seq
    import srch_cmd_pkg::*;
#(
    parameter int LKT_W  = 2,
    parameter int GM_W   = 3,
    parameter int RS_W   = 4,
    parameter int DATA_W = 16,
    parameter int ADDR_W = 8,
    parameter logic [ADDR_W-1:0] CTRL_ADDR = '1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              strobe,
    input  logic [2:0]        code,
    input  logic              legal,
    input  logic [LKT_W-1:0]  lkt_m,
    input  logic [GM_W-1:0]   gm_m,
    input  logic [RS_W-1:0]   regsel,
    input  logic [DATA_W-1:0] data,
    input  logic              addr_vld,
    input  logic [ADDR_W-1:0] cnt,
    output logic              ctr_load,
    output logic              en_q,
    output logic              op_valid,
    output logic [2:0]        op_class,
    output logic [RS_W-1:0]   op_cmp_sel,
    output logic [RS_W-1:0]   op_res_sel,
    output logic [LKT_W-1:0]  op_lktype,
    output logic [GM_W-1:0]   op_gmsel,
    output logic [ADDR_W-1:0] op_addr,
    output logic [DATA_W-1:0] op_data,
    output logic              illegal_cmd,
    output logic              proto_err
);

    logic             pend_q;
    logic             ctrl_q;
    logic [2:0]       code_q;
    logic [LKT_W-1:0] lkt_q;
    logic [GM_W-1:0]  gm_q;
    logic [RS_W-1:0]  cmp_q;
    logic             start;
    logic             is_ctrl;

    // Decode request start, counter load and control-register hit.
    always_comb begin
        start    = strobe && !pend_q && legal;
        ctr_load = start && code_is_rw(code) && addr_vld;
        is_ctrl  = (code == OP_WRITE) && addr_vld && (data[ADDR_W-1:0] == CTRL_ADDR);
    end

    // Sequence the two request cycles and issue the record.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q      <= 1'b0;
            ctrl_q      <= 1'b0;
            code_q      <= '0;
            lkt_q       <= '0;
            gm_q        <= '0;
            cmp_q       <= '0;
            en_q        <= 1'b0;
            op_valid    <= 1'b0;
            op_class    <= '0;
            op_cmp_sel  <= '0;
            op_res_sel  <= '0;
            op_lktype   <= '0;
            op_gmsel    <= '0;
            op_addr     <= '0;
            op_data     <= '0;
            illegal_cmd <= 1'b0;
            proto_err   <= 1'b0;
        end else begin
            op_valid    <= 1'b0;
            illegal_cmd <= strobe && !pend_q && !legal;
            proto_err   <= strobe && pend_q;
            if (pend_q) begin
                pend_q <= 1'b0;
                if (ctrl_q) begin
                    en_q <= data[0];
                end else if (en_q) begin
                    op_valid   <= 1'b1;
                    op_class   <= code_q;
                    op_cmp_sel <= cmp_q;
                    op_res_sel <= regsel;
                    op_lktype  <= lkt_q;
                    op_gmsel   <= gm_q;
                    op_addr    <= cnt;
                    op_data    <= data;
                end
            end else if (start) begin
                pend_q <= 1'b1;
                ctrl_q <= is_ctrl;
                code_q <= code;
                lkt_q  <= lkt_m;
                gm_q   <= gm_m;
                cmp_q  <= regsel;
            end
        end
    end

endmodule

// File: rtl/srch_cmd_decoder.sv
// Top of the search request command decoder. It joins the field mask,
// the address counter and the request sequencer. Assumes DATA_W >= ADDR_W
// and inputs that are synchronous to clk.
module srch_cmd_decoder #(
    parameter int LKT_W  = 2,
    parameter int GM_W   = 3,
    parameter int RS_W   = 4,
    parameter int DATA_W = 16,
    parameter int ADDR_W = 8,
    parameter logic [ADDR_W-1:0] CTRL_ADDR = '1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_strobe,
    input  logic [2:0]        cmd_instr,
    input  logic [LKT_W-1:0]  cmd_lktype,
    input  logic [GM_W-1:0]   cmd_gmsel,
    input  logic [RS_W-1:0]   cmd_regsel,
    input  logic [DATA_W-1:0] req_data,
    input  logic              req_addr_vld,
    input  logic              burst_adv,
    output logic              op_valid,
    output logic [2:0]        op_class,
    output logic [RS_W-1:0]   op_cmp_sel,
    output logic [RS_W-1:0]   op_res_sel,
    output logic [LKT_W-1:0]  op_lktype,
    output logic [GM_W-1:0]   op_gmsel,
    output logic [ADDR_W-1:0] op_addr,
    output logic [DATA_W-1:0] op_data,
    output logic              illegal_cmd,
    output logic              proto_err
);

    logic [LKT_W-1:0]  lkt_m;
    logic [GM_W-1:0]   gm_m;
    logic              legal;
    logic              ctr_load;
    logic              en_q;
    logic [ADDR_W-1:0] burst_cnt;

    srch_field_mask #(.LKT_W(LKT_W), .GM_W(GM_W)) u_mask (
        .code    (cmd_instr),
        .lkt_in  (cmd_lktype),
        .gm_in   (cmd_gmsel),
        .lkt_out (lkt_m),
        .gm_out  (gm_m),
        .legal   (legal)
    );

    srch_burst_ctr #(.ADDR_W(ADDR_W)) u_ctr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (ctr_load),
        .load_val (req_data[ADDR_W-1:0]),
        .adv      (burst_adv),
        .cnt      (burst_cnt)
    );

    srch_req_seq #(
        .LKT_W(LKT_W), .GM_W(GM_W), .RS_W(RS_W),
        .DATA_W(DATA_W), .ADDR_W(ADDR_W), .CTRL_ADDR(CTRL_ADDR)
    ) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .strobe      (req_strobe),
        .code        (cmd_instr),
        .legal       (legal),
        .lkt_m       (lkt_m),
        .gm_m        (gm_m),
        .regsel      (cmd_regsel),
        .data        (req_data),
        .addr_vld    (req_addr_vld),
        .cnt         (burst_cnt),
        .ctr_load    (ctr_load),
        .en_q        (en_q),
        .op_valid    (op_valid),
        .op_class    (op_class),
        .op_cmp_sel  (op_cmp_sel),
        .op_res_sel  (op_res_sel),
        .op_lktype   (op_lktype),
        .op_gmsel    (op_gmsel),
        .op_addr     (op_addr),
        .op_data     (op_data),
        .illegal_cmd (illegal_cmd),
        .proto_err   (proto_err)
    );

endmodule

// File: rtl/srch_cmd_checker.sv
// Protocol checker for the search request decoder, attached by bind.
// Assumes it observes the top's ports and its counter/enable nets.
module srch_cmd_checker #(
    parameter int LKT_W  = 2,
    parameter int GM_W   = 3,
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_strobe,
    input logic              burst_adv,
    input logic              op_valid,
    input logic [2:0]        op_class,
    input logic [LKT_W-1:0]  op_lktype,
    input logic [GM_W-1:0]   op_gmsel,
    input logic              illegal_cmd,
    input logic              proto_err,
    input logic              ctr_load,
    input logic              en_q,
    input logic [ADDR_W-1:0] burst_cnt
);

    AST_ISSUE_TWO_CYCLES: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid |-> $past(req_strobe, 2)); // R1
    AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid |=> !op_valid); // R1
    AST_LKT_MAINT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_class[2:1] != 2'b00) |-> (op_lktype == '0)); // R3
    AST_GM_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_class != 3'd0 && op_class != 3'd3) |-> (op_gmsel == '0)); // R4
    AST_NO_ILLEGAL_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid |-> (op_class <= 3'd5)); // R5
    AST_ILLEGAL_AFTER_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_cmd |-> $past(req_strobe)); // R5
    AST_PERR_AFTER_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        proto_err |-> $past(req_strobe)); // R6
    AST_BURST_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (burst_adv && !ctr_load) |=> (burst_cnt == ADDR_W'($past(burst_cnt) + 1'b1))); // R8
    AST_NO_ISSUE_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid |-> $past(en_q)); // R9

endmodule

bind srch_cmd_decoder srch_cmd_checker #(
    .LKT_W(LKT_W), .GM_W(GM_W), .ADDR_W(ADDR_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_strobe  (req_strobe),
    .burst_adv   (burst_adv),
    .op_valid    (op_valid),
    .op_class    (op_class),
    .op_lktype   (op_lktype),
    .op_gmsel    (op_gmsel),
    .illegal_cmd (illegal_cmd),
    .proto_err   (proto_err),
    .ctr_load    (ctr_load),
    .en_q        (en_q),
    .burst_cnt   (burst_cnt)
);

// File: tb/test_srch_cmd_decoder.sv
// Bench: behavioural reference model updated on each rising edge and
// compared with the design on each falling edge.
module test_srch_cmd_decoder;

    localparam int LKT_W = 2, GM_W = 3, RS_W = 4, DATA_W = 16, ADDR_W = 8;
    localparam logic [7:0] CTRL = 8'hFF;

    logic clk = 1'b0, rst_n = 1'b0;
    logic req_strobe = 0, req_addr_vld = 0, burst_adv = 0;
    logic [2:0] cmd_instr = 0;
    logic [1:0] cmd_lktype = 0;
    logic [2:0] cmd_gmsel = 0;
    logic [3:0] cmd_regsel = 0;
    logic [15:0] req_data = 0;
    logic op_valid, illegal_cmd, proto_err;
    logic [2:0] op_class;
    logic [3:0] op_cmp_sel, op_res_sel;
    logic [1:0] op_lktype;
    logic [2:0] op_gmsel;
    logic [7:0] op_addr;
    logic [15:0] op_data;

    int checks = 0, failures = 0, cycles = 0;

    srch_cmd_decoder i_srch_cmd_decoder (
        .clk(clk), .rst_n(rst_n), .req_strobe(req_strobe), .cmd_instr(cmd_instr),
        .cmd_lktype(cmd_lktype), .cmd_gmsel(cmd_gmsel), .cmd_regsel(cmd_regsel),
        .req_data(req_data), .req_addr_vld(req_addr_vld), .burst_adv(burst_adv),
        .op_valid(op_valid), .op_class(op_class), .op_cmp_sel(op_cmp_sel),
        .op_res_sel(op_res_sel), .op_lktype(op_lktype), .op_gmsel(op_gmsel),
        .op_addr(op_addr), .op_data(op_data), .illegal_cmd(illegal_cmd),
        .proto_err(proto_err)
    );

    always #10 clk = ~clk;

    // Reference model state
    bit m_pend, m_ctrl, m_en;
    int m_code, m_lkt, m_gm, m_cmp, m_cnt;
    bit e_valid, e_ill, e_perr;
    int e_class, e_cmp, e_res, e_lkt, e_gm, e_addr, e_data;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_pend = 0; m_ctrl = 0; m_en = 0; m_cnt = 0;
            e_valid = 0; e_ill = 0; e_perr = 0;
            e_class = 0; e_cmp = 0; e_res = 0; e_lkt = 0; e_gm = 0; e_addr = 0; e_data = 0;
        end else begin
            bit load;
            load = 0;
            e_valid = 0; e_ill = 0; e_perr = 0;
            if (m_pend) begin
                if (req_strobe) e_perr = 1;
                if (m_ctrl) m_en = req_data[0];
                else if (m_en) begin
                    e_valid = 1; e_class = m_code; e_cmp = m_cmp; e_res = cmd_regsel;
                    e_lkt = m_lkt; e_gm = m_gm; e_addr = m_cnt; e_data = req_data;
                end
                m_pend = 0;
            end else if (req_strobe) begin
                if (cmd_instr > 5) e_ill = 1;
                else begin
                    m_pend = 1; m_code = cmd_instr; m_cmp = cmd_regsel;
                    m_lkt = (cmd_instr <= 1) ? cmd_lktype : 0;
                    m_gm = (cmd_instr == 0 || cmd_instr == 3) ? cmd_gmsel : 0;
                    m_ctrl = (cmd_instr == 3) && req_addr_vld && (req_data[7:0] == CTRL);
                    load = (cmd_instr == 2 || cmd_instr == 3) && req_addr_vld;
                end
            end
            if (load) m_cnt = req_data[7:0];
            else if (burst_adv) m_cnt = (m_cnt + 1) % 256;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Compare outputs with the model on every falling edge
    always @(negedge clk) begin
        if (rst_n) begin
            chk("R1/R9 op_valid", op_valid, e_valid);
            chk("R5 illegal_cmd", illegal_cmd, e_ill);
            chk("R6 proto_err", proto_err, e_perr);
            if (e_valid) begin
                chk("R5 op_class", op_class, e_class);
                chk("R2 op_cmp_sel", op_cmp_sel, e_cmp);
                chk("R2 op_res_sel", op_res_sel, e_res);
                chk("R3 op_lktype", op_lktype, e_lkt);
                chk("R4 op_gmsel", op_gmsel, e_gm);
                chk("R7/R8 op_addr", op_addr, e_addr);
                chk("R7 op_data", op_data, e_data);
            end
        end
    end

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            req_strobe = 0; req_addr_vld = 0; burst_adv = 0;
        end
    endtask

    // Drive a two-cycle request; cycle-B inputs remain driven on return
    task automatic req(input logic [2:0] c, input logic [1:0] lk, input logic [2:0] gm,
                       input logic [3:0] rs1, input logic [3:0] rs2,
                       input logic [15:0] d1, input logic [15:0] d2, input bit av,
                       input bit adv_a, input bit adv_b, input bit stb_b);
        @(negedge clk);
        req_strobe = 1; cmd_instr = c; cmd_lktype = lk; cmd_gmsel = gm;
        cmd_regsel = rs1; req_data = d1; req_addr_vld = av; burst_adv = adv_a;
        @(negedge clk);
        req_strobe = stb_b; cmd_regsel = rs2; req_data = d2; req_addr_vld = 0;
        burst_adv = adv_b; cmd_lktype = ~lk; cmd_gmsel = ~gm;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R9: reset state at the ports
        chk("R9 reset op_valid", op_valid, 0);
        chk("R9 reset op_addr", op_addr, 0);
        chk("R9 reset illegal_cmd", illegal_cmd, 0);
        rst_n = 1;
        // R9: disabled, lookup not issued
        req(3'd0, 2'd2, 3'd5, 4'd3, 4'd9, 16'h1234, 16'h0, 0, 0, 0, 0); idle(2);
        // R9: enable by control write
        req(3'd3, 2'd1, 3'd1, 4'd1, 4'd2, 16'h00FF, 16'h0001, 1, 0, 0, 0); idle(1);
        // R2 R3 R4 R5: each class with fields not zero
        req(3'd0, 2'd2, 3'd5, 4'd3, 4'd9, 16'hAAAA, 16'h5555, 0, 0, 0, 0); idle(1);
        req(3'd1, 2'd3, 3'd6, 4'd4, 4'd7, 16'h0101, 16'h0202, 0, 0, 0, 0); idle(1);
        req(3'd2, 2'd3, 3'd7, 4'd5, 4'd6, 16'h0010, 16'hBEEF, 1, 0, 0, 0); idle(1);
        req(3'd3, 2'd1, 3'd2, 4'd8, 4'd1, 16'h0020, 16'hCAFE, 1, 0, 0, 0); idle(1);
        req(3'd4, 2'd2, 3'd3, 4'd2, 4'd14, 16'h0, 16'h1111, 0, 0, 0, 0); idle(1);
        req(3'd5, 2'd3, 3'd4, 4'd15, 4'd0, 16'h0, 16'h2222, 0, 0, 0, 0); idle(1);
        // R5: illegal codes
        req(3'd6, 2'd1, 3'd1, 4'd1, 4'd1, 16'h0, 16'h0, 0, 0, 0, 0); idle(1);
        req(3'd7, 2'd1, 3'd1, 4'd1, 4'd1, 16'h0, 16'h0, 1, 0, 0, 0); idle(2);
        // R6: strobe in second cycle rejected
        req(3'd0, 2'd1, 3'd3, 4'd6, 4'd11, 16'h0, 16'h3333, 0, 0, 0, 1); idle(2);
        // R7 R8: burst load then advance, load priority, advance in cycle B
        req(3'd3, 2'd0, 3'd1, 4'd0, 4'd0, 16'h0040, 16'h4444, 1, 1, 0, 0);
        idle(1); burst_adv = 1; idle(1); burst_adv = 1; idle(1);
        req(3'd3, 2'd0, 3'd2, 4'd0, 4'd0, 16'h0000, 16'h4545, 0, 0, 1, 0); idle(1);
        req(3'd3, 2'd0, 3'd2, 4'd0, 4'd0, 16'h0000, 16'h4646, 0, 1, 0, 0); idle(1);
        // R8: wrap near the top of the range
        req(3'd2, 2'd0, 3'd0, 4'd0, 4'd0, 16'h00FE, 16'h0, 1, 0, 0, 0);
        idle(1); burst_adv = 1; idle(1); burst_adv = 1; idle(1); burst_adv = 1; idle(1);
        req(3'd0, 2'd1, 3'd1, 4'd2, 4'd3, 16'h0, 16'h5151, 0, 0, 0, 0); idle(1);
        // R1: back-to-back requests
        req(3'd0, 2'd1, 3'd2, 4'd1, 4'd2, 16'h0, 16'h6161, 0, 0, 0, 0);
        req(3'd1, 2'd2, 3'd3, 4'd3, 4'd4, 16'h0, 16'h6262, 0, 0, 0, 0);
        req(3'd5, 2'd3, 3'd4, 4'd5, 4'd6, 16'h0, 16'h6363, 0, 0, 0, 0); idle(2);
        // R9: disable, lookup dropped, re-enable
        req(3'd3, 2'd0, 3'd0, 4'd0, 4'd0, 16'h00FF, 16'h0000, 1, 0, 0, 0); idle(1);
        req(3'd0, 2'd1, 3'd1, 4'd1, 4'd1, 16'h0, 16'h7777, 0, 0, 0, 0); idle(1);
        req(3'd3, 2'd0, 3'd0, 4'd0, 4'd0, 16'h00FF, 16'h0001, 1, 0, 0, 0); idle(1);
        req(3'd0, 2'd2, 3'd7, 4'd9, 4'd10, 16'h0, 16'h8888, 0, 0, 0, 0); idle(3);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    // Watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            failures++;
            $display("FAIL watchdog actual=%0d expected=<20000", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule